// File: doc/BRIEF.md
# Lockable Sixteen-Pin I/O Port Controller

This block controls a port of general-purpose pins through a small word-addressed register interface. Each pin has a 4-bit configuration field. The field selects input or output mode, output speed, open-drain drive, and pulled input. An output data word sets the level driven on each pin. Two write-only strobes set or clear selected output bits without a read-modify-write. The pin levels pass through a two-stage synchronizer and can be read as an input status word.

A lock register protects the configuration of chosen pins. It takes effect only after a fixed handshake of three writes followed by two reads. Any step out of order, or a mask that changes partway through, returns the handshake to its start with nothing locked. Once locked, the configuration fields of the masked pins and the lock register itself cannot be changed until reset. Output data, set and clear writes still act on every pin. Reads have a latency of one cycle.

Top module: `gpl_port`

## Requirements
- R1: After reset every configuration field reads 4'b0100 (floating input), the output data word is 0, and the lock register reads 0. No pin has output enable, open-drain, pull-up or pull-down active.
- R2: Configuration word 0 (address 0) holds pins 0–7 and word 1 (address 1) holds pins 8–15. Pin p sits at bits [4*(p%8)+3 : 4*(p%8)] of its word, and each word reads back as written.
- R3: In a field, bits [1:0]=00 select input mode. Any other value of bits [1:0] selects output mode, with 01 for 10 MHz, 10 for 2 MHz and 11 for 50 MHz. In output mode, bit 2 = 1 selects open-drain. pin_oe is high exactly in output mode, and pin_od is high exactly in open-drain output mode.
- R4: Pulled-input mode is bits [1:0]=00 with bits [3:2]=10. In this mode pin_pu equals the pin's output data bit and pin_pd equals its inverse. In every other mode both pull outputs are 0.
- R5: A write to address 3 loads bits [15:0] into the output data word. This word drives pin_out from the next cycle and reads back at address 3.
- R6: A write to address 4 sets each output bit whose write bit is 1. A write to address 5 clears each output bit whose write bit is 1. In both cases, bits written as 0 are unchanged.
- R7: A read of address 2 returns the pin_in levels after a two-flop synchronizer. A level applied just before a read is not yet visible to that read, and it is visible to the next read.
- R8: bus_rdata is registered. It shows the addressed register in the cycle after bus_rd. When bus_wr and bus_rd are high together, the write is performed and bus_rdata keeps its previous value.
- R9: Address 6 is the lock register: pin mask in bits [15:0], key in bit 16. A read returns the locked mask and the lock state in bit 16, both 0 while unlocked.
- R10: The lock handshake is: write key=1 with mask M, write key=0 with M, write key=1 with M, read, read. The first read returns key 0 and applies the lock with mask M. The second read returns key 1 with M.
- R11: A lock-register write or read that is out of order, or a handshake write whose mask differs from M, returns the handshake to its start and locks nothing. Accesses to other addresses do not disturb the handshake.
- R12: Once locked, configuration writes leave the fields of masked pins unchanged but still update unmasked pins. Writes to the lock register are ignored until reset.
- R13: Output data, set and clear writes act on locked pins exactly as on unlocked pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Word address of the access |
| bus_wdata | input | DW (32) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW (32) | Registered read data |
| pin_in | input | NPINS (16) | Pin levels from the pads |
| pin_out | output | NPINS (16) | Output value per pin |
| pin_oe | output | NPINS (16) | Output enable per pin |
| pin_od | output | NPINS (16) | Open-drain select per pin |
| pin_pu | output | NPINS (16) | Pull-up select per pin |
| pin_pd | output | NPINS (16) | Pull-down select per pin |

## Verification
The bench builds the block with its defaults: NPINS=16, DW=32 and ADDR_W=3. With these values there are two configuration words, the lock key lands in bit 16, and a 16-bit mask can cover every pin. Random mixes of configuration, output, set and clear writes therefore reach both configuration words and all field encodings. Directed handshakes cover each abort path, a full lock on a mixed mask, and the behaviour after the lock. This includes a second, complete handshake that must have no effect.

// File: rtl/gpl_pkg.sv
package gpl_pkg;

    // Per-pin field layout: [1:0] speed (00 = input), [3:2] sub-mode
    localparam logic [1:0] SPD_INPUT = 2'b00;
    localparam logic [1:0] IN_PULLED = 2'b10;
    localparam logic [3:0] CFG_RESET = 4'b0100;
    localparam int         FIELD_W   = 4;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ARM1,
        LK_ARM0,
        LK_ARM2,
        LK_HELD
    } lk_state_e;

endpackage

// File: rtl/gpl_sync.sv
module gpl_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpl_lock_fsm.sv
module gpl_lock_fsm
    import gpl_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             rd_hit,
    input  logic             wkey,
    input  logic [NPINS-1:0] wmask,
    output logic             locked,
    output logic [NPINS-1:0] lock_mask
);
    typedef struct packed {
        lk_state_e        state;
        logic [NPINS-1:0] seq_mask;
        logic             locked;
        logic [NPINS-1:0] mask;
    } lk_t;

    lk_t lk_d, lk_q;
    logic same_mask;

    assign same_mask = (wmask == lk_q.seq_mask);

    always_comb begin
        lk_d = lk_q;
        if (!lk_q.locked) begin
            unique case (lk_q.state)
                LK_IDLE: begin
                    if (wr_hit && wkey) begin
                        lk_d.state    = LK_ARM1;
                        lk_d.seq_mask = wmask;
                    end
                end
                LK_ARM1: begin
                    if (wr_hit)      lk_d.state = (!wkey && same_mask) ? LK_ARM0 : LK_IDLE;
                    else if (rd_hit) lk_d.state = LK_IDLE;
                end
                LK_ARM0: begin
                    if (wr_hit)      lk_d.state = (wkey && same_mask) ? LK_ARM2 : LK_IDLE;
                    else if (rd_hit) lk_d.state = LK_IDLE;
                end
                LK_ARM2: begin
                    if (wr_hit) begin
                        lk_d.state = LK_IDLE;
                    end else if (rd_hit) begin
                        lk_d.state  = LK_HELD;
                        lk_d.locked = 1'b1;
                        lk_d.mask   = lk_q.seq_mask;
                    end
                end
                default: lk_d.state = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{state: LK_IDLE, seq_mask: '0, locked: 1'b0, mask: '0};
        else        lk_q <= lk_d;
    end

    assign locked    = lk_q.locked;
    assign lock_mask = lk_q.mask;
endmodule

// File: rtl/gpl_cfg_bank.sv
module gpl_cfg_bank
    import gpl_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 32,
    localparam int PER_WORD = DW / FIELD_W,
    localparam int NCFG     = (NPINS + PER_WORD - 1) / PER_WORD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCFG-1:0]          cfg_we,
    input  logic [DW-1:0]            wdata,
    input  logic                     locked,
    input  logic [NPINS-1:0]         lock_mask,
    output logic [NPINS*FIELD_W-1:0] cfg
);
    typedef struct packed {
        logic [NPINS*FIELD_W-1:0] field;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NPINS; i++) begin
            if (cfg_we[i / PER_WORD] && !(locked && lock_mask[i])) begin
                cfg_d.field[FIELD_W*i +: FIELD_W] = wdata[FIELD_W*(i % PER_WORD) +: FIELD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q.field <= {NPINS{CFG_RESET}};
        else        cfg_q       <= cfg_d;
    end

    assign cfg = cfg_q.field;
endmodule

// File: rtl/gpl_pin_drive.sv
module gpl_pin_drive
    import gpl_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic [NPINS*FIELD_W-1:0] cfg,
    input  logic [NPINS-1:0]         out_val,
    output logic [NPINS-1:0]         oe,
    output logic [NPINS-1:0]         od,
    output logic [NPINS-1:0]         pu,
    output logic [NPINS-1:0]         pd
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [FIELD_W-1:0] f;
        logic               is_out;
        logic               pulled;
        assign f      = cfg[FIELD_W*p +: FIELD_W];
        assign is_out = (f[1:0] != SPD_INPUT);
        assign pulled = !is_out && (f[3:2] == IN_PULLED);
        assign oe[p]  = is_out;
        assign od[p]  = is_out && f[2];
        assign pu[p]  = pulled && out_val[p];
        assign pd[p]  = pulled && !out_val[p];
    end
endmodule

// File: rtl/gpl_port.sv
module gpl_port
    import gpl_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int DW     = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_od,
    output logic [NPINS-1:0]  pin_pu,
    output logic [NPINS-1:0]  pin_pd
);
    localparam int PER_WORD = DW / FIELD_W;
    localparam int NCFG     = (NPINS + PER_WORD - 1) / PER_WORD;
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(NCFG);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(NCFG + 1);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(NCFG + 2);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(NCFG + 3);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(NCFG + 4);

    typedef struct packed {
        logic [NPINS-1:0] out;
        logic [DW-1:0]    rdata;
    } port_t;

    port_t pt_d, pt_q;

    logic [NPINS*FIELD_W-1:0] cfg_flat;
    logic [NCFG-1:0]          cfg_we;
    logic [NPINS-1:0]         in_sync;
    logic                     lk_locked;
    logic [NPINS-1:0]         lk_mask;
    logic                     lk_wr_hit, lk_rd_hit;
    logic                     rd_go;
    logic [DW-1:0]            cfg_word [NCFG];

    assign rd_go     = bus_rd && !bus_wr;
    assign lk_wr_hit = bus_wr && (bus_addr == A_LOCK);
    assign lk_rd_hit = rd_go && (bus_addr == A_LOCK);

    for (genvar k = 0; k < NCFG; k++) begin : g_we
        assign cfg_we[k] = bus_wr && (bus_addr == ADDR_W'(k));
    end

    always_comb begin
        for (int k = 0; k < NCFG; k++) begin
            cfg_word[k] = '0;
            for (int s = 0; s < PER_WORD; s++) begin
                if (k * PER_WORD + s < NPINS) begin
                    cfg_word[k][FIELD_W*s +: FIELD_W] = cfg_flat[FIELD_W*(k*PER_WORD+s) +: FIELD_W];
                end
            end
        end
    end

    gpl_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    gpl_lock_fsm #(.NPINS(NPINS)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (lk_wr_hit),
        .rd_hit    (lk_rd_hit),
        .wkey      (bus_wdata[NPINS]),
        .wmask     (bus_wdata[NPINS-1:0]),
        .locked    (lk_locked),
        .lock_mask (lk_mask)
    );

    gpl_cfg_bank #(.NPINS(NPINS), .DW(DW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .wdata     (bus_wdata),
        .locked    (lk_locked),
        .lock_mask (lk_mask),
        .cfg       (cfg_flat)
    );

    gpl_pin_drive #(.NPINS(NPINS)) u_drive (
        .cfg     (cfg_flat),
        .out_val (pt_q.out),
        .oe      (pin_oe),
        .od      (pin_od),
        .pu      (pin_pu),
        .pd      (pin_pd)
    );

    always_comb begin
        pt_d = pt_q;
        if (bus_wr) begin
            if (bus_addr == A_OUT) pt_d.out = bus_wdata[NPINS-1:0];
            if (bus_addr == A_SET) pt_d.out = pt_q.out | bus_wdata[NPINS-1:0];
            if (bus_addr == A_CLR) pt_d.out = pt_q.out & ~bus_wdata[NPINS-1:0];
        end
        if (rd_go) begin
            pt_d.rdata = '0;
            for (int k = 0; k < NCFG; k++) begin
                if (bus_addr == ADDR_W'(k)) pt_d.rdata = cfg_word[k];
            end
            if (bus_addr == A_IN)  pt_d.rdata[NPINS-1:0] = in_sync;
            if (bus_addr == A_OUT) pt_d.rdata[NPINS-1:0] = pt_q.out;
            if (bus_addr == A_LOCK) begin
                pt_d.rdata[NPINS-1:0] = lk_mask;
                pt_d.rdata[NPINS]     = lk_locked;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    assign bus_rdata = pt_q.rdata;
    assign pin_out   = pt_q.out;
endmodule

// File: rtl/gpl_port_chk.sv
module gpl_port_chk #(
    parameter int NPINS  = 16,
    parameter int DW     = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              bus_wr,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pin_od,
    input logic [NPINS-1:0]  pin_pu,
    input logic [NPINS-1:0]  pin_pd,
    input logic              locked,
    input logic [NPINS-1:0]  lock_mask,
    input logic [NPINS*4-1:0] cfg
);
    localparam int NCFG = (NPINS + (DW / 4) - 1) / (DW / 4);
    localparam logic [ADDR_W-1:0] C_SET = ADDR_W'(NCFG + 2);
    localparam logic [ADDR_W-1:0] C_CLR = ADDR_W'(NCFG + 3);

    logic [NPINS*4-1:0] mask_wide;
    for (genvar p = 0; p < NPINS; p++) begin : g_mw
        assign mask_wide[4*p +: 4] = {4{lock_mask[p]}};
    end

    p_set_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == C_SET) |=>
            ((pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])) &&
            (((pin_out ^ $past(pin_out)) & ~$past(bus_wdata[NPINS-1:0])) == '0));

    p_clr_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == C_CLR) |=>
            ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0) &&
            (((pin_out ^ $past(pin_out)) & ~$past(bus_wdata[NPINS-1:0])) == '0));

    p_lock_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(lock_mask)));

    p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (((cfg ^ $past(cfg)) & mask_wide) == '0));

    p_pull_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_pd) == '0);

    p_pull_only_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pu | pin_pd) & pin_oe) == '0);

    p_od_needs_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_od & ~pin_oe) == '0);
endmodule

bind gpl_port gpl_port_chk #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_od    (pin_od),
    .pin_pu    (pin_pu),
    .pin_pd    (pin_pd),
    .locked    (lk_locked),
    .lock_mask (lk_mask),
    .cfg       (cfg_flat)
);

// File: tb/test_gpl_port.sv
module test_gpl_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_CFG0 = 3'd0, A_CFG1 = 3'd1, A_IN = 3'd2, A_OUT = 3'd3,
                           A_SET = 3'd4, A_CLR = 3'd5, A_LOCK = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pin_od, pin_pu, pin_pd;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    logic [3:0]  m_cfg [16];
    logic [15:0] m_out, m_mask;
    logic        m_locked;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpl_port i_gpl_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od), .pin_pu(pin_pu), .pin_pd(pin_pd)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cfg_word(input int k);
        logic [31:0] w = '0;
        for (int s = 0; s < 8; s++) w[4*s +: 4] = m_cfg[8*k + s];
        return w;
    endfunction

    // Expected {oe, od, pu, pd} from the field model (R3, R4)
    function automatic logic [63:0] exp_pins();
        logic [15:0] oe, od, pu, pd;
        for (int p = 0; p < 16; p++) begin
            logic o, pl;
            o  = (m_cfg[p][1:0] != 2'b00);
            pl = !o && (m_cfg[p][3:2] == 2'b10);
            oe[p] = o;
            od[p] = o && m_cfg[p][2];
            pu[p] = pl && m_out[p];
            pd[p] = pl && !m_out[p];
        end
        return {oe, od, pu, pd};
    endfunction

    task automatic model_cfg(input int k, input logic [31:0] d);
        for (int s = 0; s < 8; s++)
            if (!(m_locked && m_mask[8*k+s])) m_cfg[8*k+s] = d[4*s +: 4];
    endtask

    task automatic check_pins(input string tag);
        check({tag, " pins"}, {pin_oe, pin_od, pin_pu, pin_pd}, exp_pins());
        check({tag, " out"}, {48'h0, pin_out}, {48'h0, m_out});
    endtask

    task automatic random_ops(input int n);
        logic [31:0] d, rd;
        for (int it = 0; it < n; it++) begin
            int op;
            op = int'($urandom_range(0, 4));
            d  = $urandom;
            case (op)
                0, 1: begin
                    bus_write(3'(op), d);
                    model_cfg(op, d);
                    bus_read(3'(op), rd);
                    check("R2/R12 cfg readback", {32'h0, rd}, {32'h0, cfg_word(op)});
                end
                2: begin
                    bus_write(A_OUT, d); m_out = d[15:0];
                    bus_read(A_OUT, rd);
                    check("R5 out readback", {32'h0, rd}, {48'h0, m_out});
                end
                3: begin
                    bus_write(A_SET, d); m_out = m_out | d[15:0];
                end
                default: begin
                    bus_write(A_CLR, d); m_out = m_out & ~d[15:0];
                end
            endcase
            check_pins("R3/R4/R6");
        end
    endtask

    task automatic lock_seq(input logic [15:0] m, output logic [31:0] r1, output logic [31:0] r2);
        bus_write(A_LOCK, {15'h0, 1'b1, m});
        bus_write(A_LOCK, {15'h0, 1'b0, m});
        bus_write(A_LOCK, {15'h0, 1'b1, m});
        bus_read(A_LOCK, r1);
        bus_read(A_LOCK, r2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, r1, r2, keep;
        void'($urandom(32'h1A2B3C4D));
        for (int p = 0; p < 16; p++) m_cfg[p] = 4'b0100;
        m_out = '0; m_mask = '0; m_locked = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(A_CFG0, rd); check("R1 cfg0 reset", {32'h0, rd}, 64'h4444_4444);
        bus_read(A_CFG1, rd); check("R1 cfg1 reset", {32'h0, rd}, 64'h4444_4444);
        bus_read(A_OUT, rd);  check("R1 out reset", {32'h0, rd}, 64'h0);
        bus_read(A_LOCK, rd); check("R9 R1 lock reset", {32'h0, rd}, 64'h0);
        check_pins("R1 reset");

        // R2 field position: pin 9 output open-drain 50 MHz, pin 2 pulled input
        bus_write(A_CFG1, 32'h4444_44F4); model_cfg(1, 32'h4444_44F4);
        bus_write(A_CFG0, 32'h4444_0844); model_cfg(0, 32'h4444_0844);
        check_pins("R2 R3 field position");
        check("R3 pin9 od", {63'h0, pin_od[9]}, 64'h1);
        bus_write(A_SET, 32'h0000_0004); m_out[2] = 1'b1;
        check("R4 pin2 pull-up", {62'h0, pin_pu[2], pin_pd[2]}, 64'h2);
        bus_write(A_CLR, 32'h0000_0004); m_out[2] = 1'b0;
        check("R4 pin2 pull-down", {62'h0, pin_pu[2], pin_pd[2]}, 64'h1);

        // R7 synchronizer latency
        for (int t = 0; t < 6; t++) begin
            logic [15:0] prev, nv;
            bus_read(A_IN, rd); prev = rd[15:0];
            nv = 16'($urandom);
            @(negedge clk); pin_in = nv;
            bus_read(A_IN, rd);
            check("R7 input not yet visible", {48'h0, rd[15:0]}, {48'h0, prev});
            bus_read(A_IN, rd);
            check("R7 input visible", {32'h0, rd}, {48'h0, nv});
        end

        // R8 write wins over a simultaneous read
        bus_read(A_OUT, keep);
        @(negedge clk);
        bus_addr = A_OUT; bus_wdata = 32'h0000_A5C3; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; m_out = 16'hA5C3;
        check("R8 rdata held", {32'h0, bus_rdata}, {32'h0, keep});
        check("R8 R5 write done", {48'h0, pin_out}, {48'h0, m_out});

        random_ops(300);

        // R11 aborts: repeated key=1, changed mask, early read
        bus_write(A_LOCK, 32'h0001_00FF);
        bus_write(A_LOCK, 32'h0001_00FF);
        bus_write(A_LOCK, 32'h0000_00FF);
        bus_write(A_LOCK, 32'h0001_00FF);
        bus_read(A_LOCK, r1); bus_read(A_LOCK, r2);
        check("R11 abort on repeated key", {r1, r2}, 64'h0);
        bus_write(A_LOCK, 32'h0001_00FF);
        bus_write(A_LOCK, 32'h0000_00FE);
        bus_write(A_LOCK, 32'h0001_00FF);
        bus_read(A_LOCK, r1); bus_read(A_LOCK, r2);
        check("R11 abort on mask change", {r1, r2}, 64'h0);
        bus_write(A_LOCK, 32'h0001_00FF);
        bus_write(A_LOCK, 32'h0000_00FF);
        bus_read(A_LOCK, r1);
        bus_write(A_LOCK, 32'h0001_00FF);
        bus_read(A_LOCK, r1); bus_read(A_LOCK, r2);
        check("R11 abort on early read", {r1, r2}, 64'h0);
        bus_write(A_CFG0, 32'h1111_1111); model_cfg(0, 32'h1111_1111);
        bus_read(A_CFG0, rd);
        check("R11 nothing locked", {32'h0, rd}, 64'h1111_1111);

        // R11 unrelated access mid-sequence does not abort; R10 full handshake
        bus_write(A_LOCK, 32'h0001_0F3C);
        bus_write(A_OUT, 32'h0000_1234); m_out = 16'h1234;
        bus_write(A_LOCK, 32'h0000_0F3C);
        bus_write(A_LOCK, 32'h0001_0F3C);
        bus_read(A_LOCK, r1); bus_read(A_LOCK, r2);
        check("R10 first read key 0", {32'h0, r1}, 64'h0);
        check("R10 R9 second read key 1", {32'h0, r2}, 64'h0001_0F3C);
        m_locked = 1'b1; m_mask = 16'h0F3C;

        // R12 config frozen on masked pins only
        bus_write(A_CFG0, 32'h2222_2222); model_cfg(0, 32'h2222_2222);
        bus_write(A_CFG1, 32'h2222_2222); model_cfg(1, 32'h2222_2222);
        bus_read(A_CFG0, rd); check("R12 cfg0 partial", {32'h0, rd}, {32'h0, cfg_word(0)});
        bus_read(A_CFG1, rd); check("R12 cfg1 partial", {32'h0, rd}, {32'h0, cfg_word(1)});
        check_pins("R12 locked pins");

        // R12 lock register ignores a second full handshake
        lock_seq(16'hFFFF, r1, r2);
        check("R12 relock ignored", {r1, r2}, {32'h0001_0F3C, 32'h0001_0F3C});
        bus_write(A_CFG1, 32'h3333_3333); model_cfg(1, 32'h3333_3333);
        bus_read(A_CFG1, rd); check("R12 unmasked still writable", {32'h0, rd}, {32'h0, cfg_word(1)});

        // R13 data writes on locked pins
        bus_write(A_SET, 32'h0000_0F3C); m_out = m_out | 16'h0F3C;
        check("R13 set on locked pins", {48'h0, pin_out}, {48'h0, m_out});
        bus_write(A_CLR, 32'h0000_0F3C); m_out = m_out & ~16'h0F3C;
        check("R13 clear on locked pins", {48'h0, pin_out}, {48'h0, m_out});
        bus_write(A_OUT, 32'h0000_FFFF); m_out = 16'hFFFF;
        check("R13 R5 out on locked pins", {48'h0, pin_out}, 64'hFFFF);

        random_ops(300);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule